// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block chooses which way of an 8-way set-associative cache to replace on a miss. For every set it keeps a 7-bit binary-tree pseudo-LRU record. A lookup names a set and supplies that set's 8-bit valid vector. One clock later the block returns the chosen way. The tag array, the data array and the index decode around it are outside the block.

In normal mode an empty (invalid) way is always taken before any occupied one. When the flush-assist input is high, the valid vector is ignored and the victim comes from the tree alone. Filling each victim in turn then displaces all eight ways of a set in eight misses. This is the property a cache-flush routine relies on.

Every hit, and every fill of a chosen victim, is reported on the update port. That port steers the tree of the named set away from the accessed way. A two-state controller sequences the result. `ST_IDLE` moves to `ST_SHOW` when a lookup is accepted. `ST_SHOW` stays in `ST_SHOW` on a back-to-back lookup and returns to `ST_IDLE` otherwise. The result-valid output is high exactly in `ST_SHOW`.

Top module: `plru8_victim_sel`

## Requirements
- R1: After reset every set's tree is all zeros, so a lookup in flush-assist mode returns way 0, and `vict_vld` is low until the first lookup.
- R2: `vict_vld` is high in the cycle after each clock edge at which `lkp_vld` was sampled high, and low in every other cycle.
- R3: With `flush_mode` low and at least one zero bit in `lkp_valid` (bit i = way i), the victim is the lowest-numbered way whose bit is zero.
- R4: With `flush_mode` low and `lkp_valid` all ones, the victim is the way the tree points to.
- R5: With `flush_mode` high, the victim is the way the tree points to, whatever `lkp_valid` holds.
- R6: The tree encoding is as follows. Bit 0 is the root (1 selects ways 4-7). Bit 1 chooses within ways 0-3 and bit 2 within ways 4-7 (1 selects the upper pair). Bits 3, 4, 5 and 6 choose within the pairs (0,1), (2,3), (4,5) and (6,7) (1 selects the odd way). An update sets the three bits on the accessed way's path to point to the other side.
- R7: In flush-assist mode, starting from a zero tree, eight lookup-then-fill rounds on one set return ways 0, 4, 2, 6, 1, 5, 3, 7. This covers all eight ways.
- R8: An update to one set leaves the victim of every other set unchanged.
- R9: A lookup and an update at the same edge to the same set: the lookup sees the tree as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_vld | input | 1 | Miss lookup request |
| lkp_set | input | IDX_W | Set addressed by the lookup |
| lkp_valid | input | 8 | Valid bit per way of that set |
| flush_mode | input | 1 | Flush assist: ignore invalid ways |
| upd_vld | input | 1 | Hit or fill report |
| upd_set | input | IDX_W | Set of the reported access |
| upd_way | input | 3 | Way of the reported access |
| vict_vld | output | 1 | Victim result valid |
| vict_way | output | 3 | Chosen victim way |

## Verification
The victim for a lookup sampled at edge N is due in the cycle after edge N. The bench samples it on the falling edge that follows. Tree updates at edge N affect only lookups sampled at edge N+1 or later. The driver therefore predicts each expected way from its model before applying the same-edge update. It queues the expected way, and the monitor pops one entry on every falling edge where `vict_vld` is high. A result that arrives with an empty queue is a failure, and so is a queue that is not empty at the end.

// File: rtl/plru_pkg.sv
package plru_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ctl_state_t;

    // Walk root -> half node -> pair node.
    function automatic way_t tree_pick(input tree_t t);
        logic hi, mid, leaf;
        hi   = t[0];
        mid  = hi ? t[2] : t[1];
        leaf = t[3 + {hi, mid}];
        return {hi, mid, leaf};
    endfunction
endpackage

// File: rtl/plru_tree_pick.sv
module plru_tree_pick
    import plru_pkg::*;
(
    input  tree_t tree,
    output way_t  way
);
    always_comb begin
        way = tree_pick(tree);
    end
endmodule

// File: rtl/plru_invalid_pick.sv
module plru_invalid_pick
    import plru_pkg::*;
(
    input  logic [WAYS-1:0] valid_vec,
    output logic            any_free,
    output way_t            free_way
);
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_way = way_t'(i);
            end
        end
    end

    // R3: reported way is empty and nothing below it is empty
    always_comb begin
        if (any_free) begin
            a_lowest_free_r3: assert (valid_vec[free_way] == 1'b0);
            for (int j = 0; j < WAYS; j++) begin
                if (j < int'(free_way)) begin
                    a_none_below_r3: assert (valid_vec[j] == 1'b1);
                end
            end
        end
    end
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output tree_t            rd_tree,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_set,
    input  way_t             wr_way
);
    tree_t tree_q [NUM_SETS];
    tree_t touched;

    // Point every node on the accessed path to the other side.
    always_comb begin
        touched = tree_q[wr_set];
        touched[0] = ~wr_way[2];
        touched[1 + int'(wr_way[2])] = ~wr_way[1];
        touched[3 + int'(wr_way[2:1])] = ~wr_way[0];
    end

    logic [NUM_SETS-1:0] set_we;
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_we
        assign set_we[s] = wr_vld && (wr_set == IDX_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SETS; s++)
                if (set_we[s]) tree_q[s] <= touched;
        end
    end

    assign rd_tree = tree_q[rd_set];

    // R6: after an access the tree no longer points at that way
    p_points_away_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> tree_pick(tree_q[$past(wr_set)]) != $past(wr_way));

    // R8: set 0 only changes when it is written
    p_other_set_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_vld && wr_set == '0) |=> tree_q[0] == $past(tree_q[0]));
endmodule

// File: rtl/plru8_victim_sel.sv
module plru8_victim_sel
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_vld,
    input  logic [IDX_W-1:0] lkp_set,
    input  logic [7:0]       lkp_valid,
    input  logic             flush_mode,
    input  logic             upd_vld,
    input  logic [IDX_W-1:0] upd_set,
    input  logic [2:0]       upd_way,
    output logic             vict_vld,
    output logic [2:0]       vict_way
);
    tree_t      cur_tree;
    way_t       tree_way, free_way, pick_way;
    logic       any_free;
    ctl_state_t state_q, state_d;
    way_t       way_q;

    plru_state_array #(.NUM_SETS(NUM_SETS)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (lkp_set),
        .rd_tree(cur_tree),
        .wr_vld (upd_vld),
        .wr_set (upd_set),
        .wr_way (upd_way)
    );

    plru_tree_pick u_tree (
        .tree(cur_tree),
        .way (tree_way)
    );

    plru_invalid_pick u_free (
        .valid_vec(lkp_valid),
        .any_free (any_free),
        .free_way (free_way)
    );

    // Empty ways win unless flush assist forces tree order.
    always_comb begin
        pick_way = (any_free && !flush_mode) ? free_way : tree_way;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lkp_vld)  state_d = ST_SHOW;
            ST_SHOW: if (!lkp_vld) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (lkp_vld) way_q <= pick_way;
        end
    end

    always_comb begin
        vict_vld = (state_q == ST_SHOW);
        vict_way = way_q;
    end

    // R2: result one cycle after each lookup, never otherwise
    p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_vld |=> vict_vld);
    p_no_stray_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_vld |=> !vict_vld);
    // R5: flush assist result equals the tree decode of the looked-up set
    p_flush_tree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_vld && flush_mode) |=> vict_way == $past(tree_way));
endmodule

// File: tb/plru8_victim_sel_tb.sv
module plru8_victim_sel_tb;
    localparam int NSETS = 16;
    localparam int IW    = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lkp_vld = 1'b0;
    logic [IW-1:0] lkp_set = '0;
    logic [7:0]    lkp_valid = 8'hFF;
    logic          flush_mode = 1'b0;
    logic          upd_vld = 1'b0;
    logic [IW-1:0] upd_set = '0;
    logic [2:0]    upd_way = '0;
    logic          vict_vld;
    logic [2:0]    vict_way;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    plru8_victim_sel #(.NUM_SETS(NSETS)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_vld(lkp_vld), .lkp_set(lkp_set),
        .lkp_valid(lkp_valid), .flush_mode(flush_mode), .upd_vld(upd_vld),
        .upd_set(upd_set), .upd_way(upd_way), .vict_vld(vict_vld),
        .vict_way(vict_way)
    );

    typedef struct {
        logic [2:0] way;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [6:0] model [NSETS];

    function automatic logic [2:0] m_pick(input logic [6:0] t);
        logic h, m;
        h = t[0];
        m = h ? t[2] : t[1];
        return {h, m, t[3 + {h, m}]};
    endfunction

    task automatic m_touch(input int s, input logic [2:0] w);
        model[s][0] = ~w[2];
        model[s][1 + int'(w[2])] = ~w[1];
        model[s][3 + int'(w[2:1])] = ~w[0];
    endtask

    // One cycle: optional lookup (expected value queued) and optional update.
    // fixed_exp >= 0 overrides the model prediction.
    task automatic step(input bit lk, input int ls, input logic [7:0] vv,
                        input bit fl, input string tag, input bit up,
                        input int us, input logic [2:0] uw,
                        input int fixed_exp = -1);
        exp_t e;
        @(negedge clk);
        lkp_vld = lk; lkp_set = IW'(ls); lkp_valid = vv; flush_mode = fl;
        upd_vld = up; upd_set = IW'(us); upd_way = uw;
        if (lk) begin
            e.tag = tag;
            if (fixed_exp >= 0) e.way = 3'(fixed_exp);
            else if (!fl && vv != 8'hFF) begin
                e.way = 3'd0;
                for (int i = 7; i >= 0; i--) if (!vv[i]) e.way = 3'(i);
            end else e.way = m_pick(model[ls]);
            sb.push_back(e);
        end
        if (up) m_touch(us, uw);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        lkp_vld = 1'b0; upd_vld = 1'b0;
        @(posedge clk);
    endtask

    // Monitor: compare each result against the queue head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && vict_vld) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R2: vict_vld=1 unexpected (actual way %0d, expected no result)", vict_way);
                end else begin
                    e = sb.pop_front();
                    if (vict_way !== e.way) begin
                        bad++;
                        $display("FAIL %s: vict_way actual=%0d expected=%0d", e.tag, vict_way, e.way);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung (actual timeout, expected completion)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int sweep[8] = '{0, 4, 2, 6, 1, 5, 3, 7};

    initial begin
        for (int s = 0; s < NSETS; s++) model[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (vict_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1: vict_vld during reset actual=%b expected=0", vict_vld);
        end
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        total++;
        if (vict_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1: vict_vld after reset actual=%b expected=0", vict_vld);
        end

        // R1: zero tree -> way 0
        step(1, 0, 8'hFF, 1, "R1", 0, 0, 0, 0);
        step(1, 7, 8'h00, 1, "R1", 0, 0, 0, 0);
        idle();

        // R3: lowest empty way
        step(1, 1, 8'b1111_0110, 0, "R3", 0, 0, 0, 0);
        step(1, 1, 8'b1011_1111, 0, "R3", 0, 0, 0, 6);
        step(1, 1, 8'b0111_1111, 0, "R3", 0, 0, 0, 7);
        step(1, 1, 8'b0001_1000, 0, "R3", 0, 0, 0, 0);
        idle(); idle();

        // R7 / R5: flush sweep on set 3 with all ways marked empty
        for (int k = 0; k < 8; k++) begin
            step(1, 3, 8'h00, 1, "R7", 0, 0, 0, sweep[k]);
            step(0, 0, 8'hFF, 1, "R7", 1, 3, 3'(sweep[k]));
        end
        idle();

        // R4 / R6: hits on set 5, then tree-order victims with all valid
        step(0, 0, 8'hFF, 0, "R6", 1, 5, 3'd6);
        step(1, 5, 8'hFF, 0, "R6", 0, 0, 0, 0);
        step(0, 0, 8'hFF, 0, "R4", 1, 5, 3'd1);
        step(1, 5, 8'hFF, 0, "R4", 0, 0, 0, 4);
        step(0, 0, 8'hFF, 0, "R4", 1, 5, 3'd3);
        step(1, 5, 8'hFF, 0, "R4", 0, 0, 0);
        step(1, 5, 8'hF0, 1, "R5", 1, 5, 3'd4);
        step(1, 5, 8'h0F, 1, "R5", 0, 0, 0);
        idle();

        // R8: set 3 back to start of sweep (all eight filled); unaffected by set 5
        step(1, 3, 8'hFF, 1, "R8", 1, 5, 3'd0, 0);
        step(1, 9, 8'hFF, 1, "R8", 0, 0, 0, 0);
        idle();

        // R9: same-edge lookup and update on set 2 sees old tree
        step(1, 2, 8'hFF, 1, "R9", 1, 2, 3'd0, 0);
        step(1, 2, 8'hFF, 1, "R9", 0, 0, 0, 4);
        idle(); idle(); idle();

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2: results missing actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule